// File: doc/BRIEF.md
# LIN Error Status and Detection Unit

This block keeps the error and event flags of a LIN bus controller and contains the logic that raises them. It watches the received bus level, paced by a bit-time tick, for a bus held dominant too long. It compares an 8-bit timeout counter against two compare values. It also takes one-cycle error strobes from the frame engine and qualifies them by protocol phase, controller role and checksum configuration before it latches them.

Software reads the flags as one 32-bit status word and clears any flag by writing a one to it through a clear mask. The unit drives two outputs. The first is a level-sensitive header interrupt request, formed from the three header-related error flags and their enable. The second is a request to return to idle, which is active while a timeout compare event is latched and the idle-on-timeout control is set.

The stuck-bus watcher is a three-state machine. WATCH is the rest state with a count of zero. On a dominant sample with a tick, WATCH moves to COUNT. COUNT moves to WATCH when a recessive sample arrives. COUNT moves to SAT on the tick that takes the run past the limit, and that tick raises the flag. SAT holds the count frozen and moves back to WATCH only on a recessive sample.

Top module: `lin_err_status`

## Requirements
- R1: The stuck flag (status bit 0) is set on the 101st consecutive bit tick seen while `rx_level` is 0. It is not set after 100 such ticks. Only software clears it.
- R2: Any cycle with `rx_level` = 1 restarts the dominant run count. Once the flag has been raised, the count saturates. Further dominant ticks never raise the flag again until a recessive sample has been seen.
- R3: The timeout compare flag (status bit 1) is set in the cycle after `tmo_count` equals `cmp_a` or `cmp_b`.
- R4: `idle_req` is 1 exactly when status bit 1 is set and `idle_on_tmo` is 1.
- R5: When `tmo_mode_en` is 1, a rising edge of `init_mode` clears status bit 1. When `tmo_mode_en` is 0, entering init mode leaves the bit unchanged.
- R6: The bit error flag (status bit 2) is set by `ev_bit_err` in the response phase (`hdr_phase` = 0) in any role. In the header phase (`hdr_phase` = 1) it is set only when `master_mode` = 1.
- R7: The checksum flag (status bit 3) is set by `ev_cksum_err` only when both `cksum_calc_off` and `cksum_field_off` are 0.
- R8: The strobes `ev_sync_err`, `ev_delim_short` and `ev_id_parity` set status bits 4, 5 and 6 respectively.
- R9: `hdr_irq` equals `hdr_irq_en` AND (bit 4 OR bit 5 OR bit 6).
- R10: After reset all status bits are 0. A 1 in `sw_clr[i]` clears flag i, and a 0 leaves it unchanged. Bits 31 down to 7 always read as 0.
- R11: If a set condition and a software clear of the same flag occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 1 | Sampled bus level, 0 = dominant |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| ev_bit_err | input | 1 | Bit mismatch strobe |
| hdr_phase | input | 1 | 1 while a header is being sent |
| master_mode | input | 1 | 1 when the controller is master |
| ev_cksum_err | input | 1 | Checksum mismatch strobe |
| ev_sync_err | input | 1 | Sync field inconsistency strobe |
| ev_delim_short | input | 1 | Break delimiter too short strobe |
| ev_id_parity | input | 1 | Identifier parity fault strobe |
| cksum_calc_off | input | 1 | Checksum calculation disabled |
| cksum_field_off | input | 1 | Checksum field disabled |
| tmo_count | input | 8 | Free-running timeout counter |
| cmp_a | input | 8 | First compare value |
| cmp_b | input | 8 | Second compare value |
| init_mode | input | 1 | Controller is in initialization mode |
| tmo_mode_en | input | 1 | Mode entry clears the compare flag |
| idle_on_tmo | input | 1 | Compare event requests idle |
| hdr_irq_en | input | 1 | Header error interrupt enable |
| sw_clr | input | 7 | Write-one-to-clear mask, bit i clears flag i |
| status | output | 32 | Flag word |
| hdr_irq | output | 1 | Header error interrupt request |
| idle_req | output | 1 | Request to return to idle |

## Verification
The hardest state to reach from the ports is the saturated stuck watcher while its flag has been cleared. It takes more than a hundred dominant ticks, a software clear, and then a further long run of dominant ticks that must not raise the flag a second time. The bench sweeps run lengths from 98 to 103 ticks around the threshold. It then holds the bus dominant past the flag, clears the flag, and applies two hundred more ticks, enough to wrap any counter of the minimum width if it were not frozen. Compare matching is swept over all 256 counter values, and every qualifying combination of phase, role, checksum disable and interrupt enable is enumerated.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
    localparam int STAT_W    = 32;
    localparam int NFLAG     = 7;
    localparam int FLG_STUCK = 0;
    localparam int FLG_OC    = 1;
    localparam int FLG_BIT   = 2;
    localparam int FLG_CKS   = 3;
    localparam int FLG_SYNC  = 4;
    localparam int FLG_DELIM = 5;
    localparam int FLG_IDPAR = 6;

    typedef enum logic [1:0] {
        SD_WATCH = 2'd0,
        SD_COUNT = 2'd1,
        SD_SAT   = 2'd2
    } stuck_state_e;
endpackage

// File: rtl/lin_stuck_det.sv
module lin_stuck_det
    import lin_err_pkg::*;
#(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_level,
    input  logic bit_tick,
    output logic stuck_set
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    stuck_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SD_WATCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SD_WATCH: begin
                cnt_d = '0;
                if (!rx_level && bit_tick) begin
                    state_d = SD_COUNT;
                    cnt_d   = CW'(1);
                end
            end
            SD_COUNT: begin
                if (rx_level) begin
                    state_d = SD_WATCH;
                    cnt_d   = '0;
                end else if (bit_tick) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == LIM_V) state_d = SD_SAT;
                end
            end
            SD_SAT: begin
                if (rx_level) begin
                    state_d = SD_WATCH;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = SD_WATCH;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        stuck_set = 1'b0;
        unique case (state_q)
            SD_COUNT: stuck_set = !rx_level && bit_tick && (cnt_q == LIM_V);
            default:  stuck_set = 1'b0;
        endcase
    end
endmodule

// File: rtl/lin_oc_match.sv
module lin_oc_match #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmo_count,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             init_mode,
    input  logic             tmo_mode_en,
    output logic             oc_hit,
    output logic             oc_hw_clr
);
    logic init_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) init_q <= 1'b0;
        else        init_q <= init_mode;
    end

    always_comb begin
        oc_hit    = (tmo_count == cmp_a) || (tmo_count == cmp_b);
        oc_hw_clr = init_mode && !init_q && tmo_mode_en;
    end
endmodule

// File: rtl/lin_flag_bank.sv
module lin_flag_bank #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_v,
    input  logic [NF-1:0] sw_clr_v,
    input  logic [NF-1:0] hw_clr_v,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags[i] <= 1'b0;
            else if (set_v[i]) flags[i] <= 1'b1;
            else if (sw_clr_v[i] || hw_clr_v[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_err_status.sv
module lin_err_status
    import lin_err_pkg::*;
#(
    parameter int STUCK_LIMIT = 100,
    parameter int CNT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_level,
    input  logic              bit_tick,
    input  logic              ev_bit_err,
    input  logic              hdr_phase,
    input  logic              master_mode,
    input  logic              ev_cksum_err,
    input  logic              ev_sync_err,
    input  logic              ev_delim_short,
    input  logic              ev_id_parity,
    input  logic              cksum_calc_off,
    input  logic              cksum_field_off,
    input  logic [CNT_W-1:0]  tmo_count,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic              init_mode,
    input  logic              tmo_mode_en,
    input  logic              idle_on_tmo,
    input  logic              hdr_irq_en,
    input  logic [NFLAG-1:0]  sw_clr,
    output logic [STAT_W-1:0] status,
    output logic              hdr_irq,
    output logic              idle_req
);
    logic             stuck_set, oc_hit, oc_hw_clr;
    logic [NFLAG-1:0] set_v, hw_clr_v, flags;

    lin_stuck_det #(.LIMIT(STUCK_LIMIT)) u_stuck (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
        .bit_tick(bit_tick), .stuck_set(stuck_set)
    );

    lin_oc_match #(.CNT_W(CNT_W)) u_oc (
        .clk(clk), .rst_n(rst_n), .tmo_count(tmo_count),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .init_mode(init_mode),
        .tmo_mode_en(tmo_mode_en), .oc_hit(oc_hit), .oc_hw_clr(oc_hw_clr)
    );

    always_comb begin
        set_v            = '0;
        set_v[FLG_STUCK] = stuck_set;
        set_v[FLG_OC]    = oc_hit;
        set_v[FLG_BIT]   = ev_bit_err && (!hdr_phase || master_mode);
        set_v[FLG_CKS]   = ev_cksum_err && !cksum_calc_off && !cksum_field_off;
        set_v[FLG_SYNC]  = ev_sync_err;
        set_v[FLG_DELIM] = ev_delim_short;
        set_v[FLG_IDPAR] = ev_id_parity;
        hw_clr_v         = '0;
        hw_clr_v[FLG_OC] = oc_hw_clr;
    end

    lin_flag_bank #(.NF(NFLAG)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_v(set_v), .sw_clr_v(sw_clr),
        .hw_clr_v(hw_clr_v), .flags(flags)
    );

    always_comb begin
        status   = {{(STAT_W-NFLAG){1'b0}}, flags};
        hdr_irq  = hdr_irq_en && (flags[FLG_SYNC] || flags[FLG_DELIM] || flags[FLG_IDPAR]);
        idle_req = flags[FLG_OC] && idle_on_tmo;
    end
endmodule

// File: rtl/lin_err_status_chk.sv
module lin_err_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_sync_err,
    input logic        cksum_calc_off,
    input logic        cksum_field_off,
    input logic [7:0]  tmo_count,
    input logic [7:0]  cmp_a,
    input logic [7:0]  cmp_b,
    input logic        tmo_mode_en,
    input logic        idle_on_tmo,
    input logic        hdr_irq_en,
    input logic [6:0]  sw_clr,
    input logic [31:0] status,
    input logic        hdr_irq,
    input logic        idle_req
);
    p_stuck_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] && !sw_clr[0] |=> status[0]);

    p_oc_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_count == cmp_a || tmo_count == cmp_b) |=> status[1]);

    p_idle_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] && idle_on_tmo |-> idle_req);

    p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1] |-> !idle_req);

    p_oc_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_mode_en && status[1] && !sw_clr[1] |=> status[1]);

    p_cks_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cksum_calc_off || cksum_field_off) && !status[3] |=> !status[3]);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_irq_en |-> !hdr_irq);

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status[31:7] == '0);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sync_err && sw_clr[4] |=> status[4]);
endmodule

bind lin_err_status lin_err_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_sync_err(ev_sync_err),
    .cksum_calc_off(cksum_calc_off), .cksum_field_off(cksum_field_off),
    .tmo_count(tmo_count), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .tmo_mode_en(tmo_mode_en), .idle_on_tmo(idle_on_tmo),
    .hdr_irq_en(hdr_irq_en), .sw_clr(sw_clr), .status(status),
    .hdr_irq(hdr_irq), .idle_req(idle_req)
);

// File: tb/lin_err_status_tb.sv
module lin_err_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_level = 1'b1, bit_tick = 1'b0;
    logic        ev_bit_err = 1'b0, hdr_phase = 1'b0, master_mode = 1'b0;
    logic        ev_cksum_err = 1'b0, ev_sync_err = 1'b0;
    logic        ev_delim_short = 1'b0, ev_id_parity = 1'b0;
    logic        cksum_calc_off = 1'b0, cksum_field_off = 1'b0;
    logic [7:0]  tmo_count = 8'd0, cmp_a = 8'd255, cmp_b = 8'd254;
    logic        init_mode = 1'b0, tmo_mode_en = 1'b0, idle_on_tmo = 1'b0;
    logic        hdr_irq_en = 1'b0;
    logic [6:0]  sw_clr = 7'd0;
    logic [31:0] status;
    logic        hdr_irq, idle_req;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    lin_err_status u_dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .bit_tick(bit_tick),
        .ev_bit_err(ev_bit_err), .hdr_phase(hdr_phase), .master_mode(master_mode),
        .ev_cksum_err(ev_cksum_err), .ev_sync_err(ev_sync_err),
        .ev_delim_short(ev_delim_short), .ev_id_parity(ev_id_parity),
        .cksum_calc_off(cksum_calc_off), .cksum_field_off(cksum_field_off),
        .tmo_count(tmo_count), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .init_mode(init_mode), .tmo_mode_en(tmo_mode_en),
        .idle_on_tmo(idle_on_tmo), .hdr_irq_en(hdr_irq_en), .sw_clr(sw_clr),
        .status(status), .hdr_irq(hdr_irq), .idle_req(idle_req)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        sw_clr = 7'h7f;
        step();
        sw_clr = 7'd0;
    endtask

    task automatic dom_ticks(input int n);
        rx_level = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            step();
        end
    endtask

    initial begin
        #(10 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        chk("R10 reset status", status, 32'd0);
        chk("R10 reset irq", {30'd0, hdr_irq, idle_req}, 32'd0);
        rst_n = 1'b1;
        step();

        // R1: threshold sweep
        for (int n = 98; n <= 103; n++) begin
            rx_level = 1'b1; step();
            clear_all();
            dom_ticks(n);
            chk("R1 stuck threshold", {31'd0, status[0]}, {31'd0, n > 100});
        end
        // R1: flag sticky while bus recovers
        rx_level = 1'b1; step(); step();
        chk("R1 stuck sticky", {31'd0, status[0]}, 32'd1);

        // R2: recessive sample restarts the run
        clear_all();
        dom_ticks(60);
        rx_level = 1'b1; step();
        dom_ticks(60);
        chk("R2 run restart", {31'd0, status[0]}, 32'd0);
        // R2: saturation, no second raise after clear
        rx_level = 1'b1; step();
        dom_ticks(101);
        chk("R2 raised", {31'd0, status[0]}, 32'd1);
        clear_all();
        dom_ticks(200);
        chk("R2 saturated no wrap", {31'd0, status[0]}, 32'd0);
        rx_level = 1'b1; step();

        // R3: compare sweep
        cmp_a = 8'd37; cmp_b = 8'd200;
        for (int c = 0; c < 256; c++) begin
            tmo_count = 8'(c);
            step();
            chk("R3 compare", {31'd0, status[1]}, {31'd0, (c == 37) || (c == 200)});
            tmo_count = 8'd100;
            clear_all();
        end

        // R4: idle request
        tmo_count = 8'd37; step(); tmo_count = 8'd100;
        idle_on_tmo = 1'b0; step();
        chk("R4 idle off", {31'd0, idle_req}, 32'd0);
        idle_on_tmo = 1'b1; step();
        chk("R4 idle on", {31'd0, idle_req}, 32'd1);

        // R5: mode entry keeps flag when disabled
        tmo_mode_en = 1'b0; init_mode = 1'b1; step(); step();
        chk("R5 keep", {31'd0, status[1]}, 32'd1);
        init_mode = 1'b0; step();
        tmo_mode_en = 1'b1; init_mode = 1'b1; step();
        chk("R5 hw clear", {31'd0, status[1]}, 32'd0);
        chk("R4 idle drop", {31'd0, idle_req}, 32'd0);
        tmo_count = 8'd200; step(); tmo_count = 8'd100; step();
        chk("R5 only on entry", {31'd0, status[1]}, 32'd1);
        init_mode = 1'b0; tmo_mode_en = 1'b0; idle_on_tmo = 1'b0;
        cmp_a = 8'd255; cmp_b = 8'd254; tmo_count = 8'd0;
        clear_all();

        // R6: bit error qualification
        for (int k = 0; k < 8; k++) begin
            hdr_phase = k[2]; master_mode = k[1]; ev_bit_err = k[0];
            step();
            ev_bit_err = 1'b0;
            chk("R6 bit error", {31'd0, status[2]},
                {31'd0, k[0] && (!k[2] || k[1])});
            clear_all();
        end

        // R7: checksum suppression
        for (int k = 0; k < 4; k++) begin
            cksum_calc_off = k[1]; cksum_field_off = k[0]; ev_cksum_err = 1'b1;
            step();
            ev_cksum_err = 1'b0;
            chk("R7 checksum", {31'd0, status[3]}, {31'd0, k == 0});
            clear_all();
        end
        cksum_calc_off = 1'b0; cksum_field_off = 1'b0;

        // R8 and R9: header strobes and interrupt
        for (int k = 0; k < 16; k++) begin
            hdr_irq_en = k[3];
            ev_sync_err = k[0]; ev_delim_short = k[1]; ev_id_parity = k[2];
            step();
            ev_sync_err = 1'b0; ev_delim_short = 1'b0; ev_id_parity = 1'b0;
            chk("R8 header flags", {29'd0, status[6:4]}, {29'd0, 3'(k)});
            chk("R9 header irq", {31'd0, hdr_irq}, {31'd0, k[3] && (k[2:0] != 3'd0)});
            clear_all();
        end

        // R10: per-bit clear, zero write has no effect
        ev_sync_err = 1'b1; ev_delim_short = 1'b1; ev_id_parity = 1'b1;
        step();
        ev_sync_err = 1'b0; ev_delim_short = 1'b0; ev_id_parity = 1'b0;
        sw_clr = 7'd0; step();
        chk("R10 zero write", status, 32'h70);
        sw_clr = 7'h20; step(); sw_clr = 7'd0;
        chk("R10 single clear", status, 32'h50);
        clear_all();
        chk("R10 all clear", status, 32'd0);

        // R11: set beats clear
        ev_id_parity = 1'b1; sw_clr = 7'h40; step();
        ev_id_parity = 1'b0; sw_clr = 7'd0;
        chk("R11 set wins", status, 32'h40);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule